// File: doc/BRIEF.md
# SHA-256 Single-Block Compression Engine

This block computes the SHA-256 hash of one 512-bit message block that has already been padded. A one-cycle `start_i` strobe, seen while the engine is idle, captures `block_i`. The engine then works through two phases in sequence and never overlaps them. The first phase fills a 64-word message schedule, one word per cycle. The second phase runs the 64 compression rounds. Those rounds start from the standard SHA-256 initial hash value and read their round constants from an internal registered constant store.

When the rounds finish, the engine adds each working variable to its initial hash word. The 256-bit result goes into a digest register, and `done_o` pulses for one cycle. The digest register keeps that value until the next completion. A `start_i` that arrives while the engine is busy has no effect. Padding, chaining over several blocks and double hashing are left to the logic around this block.

Top module: `sha256_block_core`

## Requirements
- R1: After a synchronous reset (`rst_i` high at a clock edge), `done_o` is 0 and `digest_o` is all zeros.
- R2: When `start_i` is sampled high at a clock edge while the engine is idle, `done_o` goes high exactly 129 clock edges later. This is 64 schedule cycles, then 64 round cycles, then one cycle to form the digest.
- R3: The digest is the SHA-256 compression of the captured block, using the standard initial hash value and the 64 standard round constants. Each working variable is added modulo 2^32 to its initial hash word. Word a sits in `digest_o[255:224]` and word h in `digest_o[31:0]`.
- R4: Message word 0 is `block_i[511:480]` and word 15 is `block_i[31:0]`. Each word is big-endian within its 32 bits.
- R5: While the engine is busy, from the accepting edge up to the edge that raises `done_o`, `start_i` and `block_i` have no effect. The pending result and its timing do not change.
- R6: `done_o` is high for exactly one clock cycle per accepted start.
- R7: `digest_o` changes only at the edge that raises `done_o`. Between completions it holds the last result.
- R8: The round-constant store has one cycle of read latency. The constant for round t is addressed in the cycle before round t executes, so the last schedule cycle addresses round 0.
- R9: A `start_i` sampled in the cycle where `done_o` is high is accepted, so jobs can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to hash `block_i`; acted on only when idle |
| block_i | input | 512 | Padded message block, word 0 in the top 32 bits |
| done_o | output | 1 | One-cycle pulse when `digest_o` holds a new result |
| digest_o | output | 256 | SHA-256 digest, word a in the top 32 bits |

## Verification
The assertions make two assumptions. The first is that `start_i` is synchronous to `clk_i` and holds steady around the rising edge. The second is that the internal load of the working variables never coincides with a round step, which the sequencer ensures by accepting starts only in the idle phase. The stimulus changes `start_i` and `block_i` only on the falling edge. It deliberately raises `start_i`, with a different block, during both the schedule phase and the round phase. It holds `start_i` high over several whole jobs and issues a start in the same cycle as `done_o`. This covers every way a request can meet a busy engine without breaking the synchronous-input assumption.

// File: rtl/sha256_pkg.sv
package sha256_pkg;

  localparam int WORD_W      = 32;
  localparam int BLOCK_WORDS = 16;
  localparam int SCHED_LEN   = 64;
  localparam int ROUND_CNT   = 64;
  localparam int VAR_CNT     = 8;
  localparam int BLOCK_W     = WORD_W * BLOCK_WORDS;
  localparam int DIGEST_W    = WORD_W * VAR_CNT;
  localparam int IDX_W       = $clog2(SCHED_LEN);

  typedef logic [WORD_W-1:0] word_t;

  // Working variables; field a lands in the most significant position.
  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
    word_t e;
    word_t f;
    word_t g;
    word_t h;
  } wvars_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_EXPAND = 2'd1,
    PH_ROUND  = 2'd2,
    PH_FINAL  = 2'd3
  } phase_e;

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_sig0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_sig1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t small_sig0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t small_sig1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t choose(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t majority(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

  // Schedule word t from words t-2, t-7, t-15 and t-16.
  function automatic word_t sched_word(input word_t back2, input word_t back7,
                                       input word_t back15, input word_t back16);
    return small_sig1(back2) + back7 + small_sig0(back15) + back16;
  endfunction

  function automatic wvars_t init_hash();
    wvars_t v;
    v.a = 32'h6a09e667;
    v.b = 32'hbb67ae85;
    v.c = 32'h3c6ef372;
    v.d = 32'ha54ff53a;
    v.e = 32'h510e527f;
    v.f = 32'h9b05688c;
    v.g = 32'h1f83d9ab;
    v.h = 32'h5be0cd19;
    return v;
  endfunction

  function automatic wvars_t do_round(input wvars_t v, input word_t k, input word_t w);
    wvars_t n;
    word_t  t1;
    word_t  t2;
    t1  = v.h + big_sig1(v.e) + choose(v.e, v.f, v.g) + k + w;
    t2  = big_sig0(v.a) + majority(v.a, v.b, v.c);
    n.a = t1 + t2;
    n.b = v.a;
    n.c = v.b;
    n.d = v.c;
    n.e = v.d + t1;
    n.f = v.e;
    n.g = v.f;
    n.h = v.g;
    return n;
  endfunction

  function automatic wvars_t fold_hash(input wvars_t base, input wvars_t v);
    wvars_t r;
    r.a = base.a + v.a;
    r.b = base.b + v.b;
    r.c = base.c + v.c;
    r.d = base.d + v.d;
    r.e = base.e + v.e;
    r.f = base.f + v.f;
    r.g = base.g + v.g;
    r.h = base.h + v.h;
    return r;
  endfunction

endpackage

// File: rtl/sha256_kconst_rom.sv
module sha256_kconst_rom #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic [AW-1:0]     addr_i,
  output logic [DATA_W-1:0] data_o
);

  function automatic logic [31:0] k_at(input logic [AW-1:0] idx);
    logic [31:0] k;
    case (idx)
      0:  k = 32'h428a2f98;  1:  k = 32'h71374491;  2:  k = 32'hb5c0fbcf;  3:  k = 32'he9b5dba5;
      4:  k = 32'h3956c25b;  5:  k = 32'h59f111f1;  6:  k = 32'h923f82a4;  7:  k = 32'hab1c5ed5;
      8:  k = 32'hd807aa98;  9:  k = 32'h12835b01;  10: k = 32'h243185be;  11: k = 32'h550c7dc3;
      12: k = 32'h72be5d74;  13: k = 32'h80deb1fe;  14: k = 32'h9bdc06a7;  15: k = 32'hc19bf174;
      16: k = 32'he49b69c1;  17: k = 32'hefbe4786;  18: k = 32'h0fc19dc6;  19: k = 32'h240ca1cc;
      20: k = 32'h2de92c6f;  21: k = 32'h4a7484aa;  22: k = 32'h5cb0a9dc;  23: k = 32'h76f988da;
      24: k = 32'h983e5152;  25: k = 32'ha831c66d;  26: k = 32'hb00327c8;  27: k = 32'hbf597fc7;
      28: k = 32'hc6e00bf3;  29: k = 32'hd5a79147;  30: k = 32'h06ca6351;  31: k = 32'h14292967;
      32: k = 32'h27b70a85;  33: k = 32'h2e1b2138;  34: k = 32'h4d2c6dfc;  35: k = 32'h53380d13;
      36: k = 32'h650a7354;  37: k = 32'h766a0abb;  38: k = 32'h81c2c92e;  39: k = 32'h92722c85;
      40: k = 32'ha2bfe8a1;  41: k = 32'ha81a664b;  42: k = 32'hc24b8b70;  43: k = 32'hc76c51a3;
      44: k = 32'hd192e819;  45: k = 32'hd6990624;  46: k = 32'hf40e3585;  47: k = 32'h106aa070;
      48: k = 32'h19a4c116;  49: k = 32'h1e376c08;  50: k = 32'h2748774c;  51: k = 32'h34b0bcb5;
      52: k = 32'h391c0cb3;  53: k = 32'h4ed8aa4a;  54: k = 32'h5b9cca4f;  55: k = 32'h682e6ff3;
      56: k = 32'h748f82ee;  57: k = 32'h78a5636f;  58: k = 32'h84c87814;  59: k = 32'h8cc70208;
      60: k = 32'h90befffa;  61: k = 32'ha4506ceb;  62: k = 32'hbef9a3f7;  63: k = 32'hc67178f2;
      default: k = 32'h0;
    endcase
    return k;
  endfunction

  logic [DATA_W-1:0] data_q;

  // Registered read: one cycle from address to data.
  always_ff @(posedge clk_i) begin
    data_q <= DATA_W'(k_at(addr_i));
  end

  assign data_o = data_q;

endmodule

// File: rtl/sha256_msg_sched.sv
module sha256_msg_sched #(
  parameter int WORDS    = 64,
  parameter int IN_WORDS = 16,
  parameter int WW       = 32,
  localparam int IW      = $clog2(WORDS),
  localparam int BLK_W   = WW * IN_WORDS
) (
  input  logic             clk_i,
  input  logic             load_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [IW-1:0]    rd_idx_i,
  output logic [WW-1:0]    rd_word_o
);

  logic [BLK_W-1:0]          blk_q;
  logic [WORDS-1:0][WW-1:0]  w_flat;

  always_ff @(posedge clk_i) begin
    if (load_i) blk_q <= blk_i;
  end

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
    logic [WW-1:0] word_q;
    logic          hit_w;
    assign hit_w      = wr_en_i && (wr_idx_i == IW'(gi));
    assign w_flat[gi] = word_q;
    if (gi < IN_WORDS) begin : g_copy
      always_ff @(posedge clk_i) begin
        if (hit_w) word_q <= blk_q[BLK_W-1-WW*gi -: WW];
      end
    end else begin : g_expand
      always_ff @(posedge clk_i) begin
        if (hit_w) word_q <= sha256_pkg::sched_word(w_flat[gi-2], w_flat[gi-7],
                                                    w_flat[gi-15], w_flat[gi-16]);
      end
    end
  end

  assign rd_word_o = w_flat[rd_idx_i];

  // R5
  quiet_load_chk: assert property (@(posedge clk_i) load_i |-> !wr_en_i)
    else $error("block captured during schedule expansion");

endmodule

// File: rtl/sha256_round_core.sv
module sha256_round_core
  import sha256_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_i,
  input  logic   init_i,
  input  logic   step_i,
  input  word_t  k_i,
  input  word_t  w_i,
  output wvars_t vars_o
);

  wvars_t vars_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      vars_q <= '0;
    end else if (init_i) begin
      vars_q <= init_hash();
    end else if (step_i) begin
      vars_q <= do_round(vars_q, k_i, w_i);
    end
  end

  assign vars_o = vars_q;

  // R3
  init_step_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(init_i && step_i))
    else $error("working variables loaded during a round");

endmodule

// File: rtl/sha256_block_core.sv
module sha256_block_core
  import sha256_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                start_i,
  input  logic [BLOCK_W-1:0]  block_i,
  output logic                done_o,
  output logic [DIGEST_W-1:0] digest_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SCHED_LEN - 1);

  phase_e                phase_q;
  logic [IDX_W-1:0]      cnt_q;
  logic                  done_q;
  logic [DIGEST_W-1:0]   digest_q;

  logic                  idle_w;
  logic                  accept_w;
  logic                  expand_w;
  logic                  round_w;
  logic                  last_w;
  logic [IDX_W-1:0]      rom_addr_w;
  word_t                 k_cur_w;
  word_t                 w_cur_w;
  wvars_t                vars_w;

  assign idle_w   = (phase_q == PH_IDLE);
  assign accept_w = idle_w && start_i;
  assign expand_w = (phase_q == PH_EXPAND);
  assign round_w  = (phase_q == PH_ROUND);
  assign last_w   = (cnt_q == LAST_IDX);

  // Constant for round t is fetched one cycle early; during expansion the
  // store is parked on round 0 so the last schedule cycle pre-loads it.
  assign rom_addr_w = round_w ? (cnt_q + IDX_W'(1)) : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      digest_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_EXPAND;
            cnt_q   <= '0;
          end
        end
        PH_EXPAND: begin
          cnt_q <= cnt_q + IDX_W'(1);
          if (last_w) phase_q <= PH_ROUND;
        end
        PH_ROUND: begin
          cnt_q <= cnt_q + IDX_W'(1);
          if (last_w) phase_q <= PH_FINAL;
        end
        PH_FINAL: begin
          digest_q <= fold_hash(init_hash(), vars_w);
          done_q   <= 1'b1;
          phase_q  <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  sha256_msg_sched #(
    .WORDS    (SCHED_LEN),
    .IN_WORDS (BLOCK_WORDS),
    .WW       (WORD_W)
  ) sched_i (
    .clk_i     (clk_i),
    .load_i    (accept_w),
    .blk_i     (block_i),
    .wr_en_i   (expand_w),
    .wr_idx_i  (cnt_q),
    .rd_idx_i  (cnt_q),
    .rd_word_o (w_cur_w)
  );

  sha256_kconst_rom #(
    .DEPTH  (ROUND_CNT),
    .DATA_W (WORD_W)
  ) krom_i (
    .clk_i  (clk_i),
    .addr_i (rom_addr_w),
    .data_o (k_cur_w)
  );

  sha256_round_core round_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .init_i (accept_w),
    .step_i (round_w),
    .k_i    (k_cur_w),
    .w_i    (w_cur_w),
    .vars_o (vars_w)
  );

  assign done_o   = done_q;
  assign digest_o = digest_q;

  // R2
  phase_order_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (expand_w && last_w) |=> round_w)
    else $error("rounds did not follow the full schedule phase");

  // R5
  restart_ignored_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ((expand_w || round_w) && start_i) |=> (cnt_q == IDX_W'($past(cnt_q) + 1)))
    else $error("busy engine reacted to start");

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o)
    else $error("done held longer than one cycle");

  // R7
  digest_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !done_o |-> $stable(digest_o))
    else $error("digest changed without completion");

  // R8
  k_lead_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    round_w |-> ($past(rom_addr_w) == cnt_q))
    else $error("round constant not addressed one cycle ahead");

endmodule

// File: tb/sha256_block_core_tb_top.sv
module sha256_block_core_tb_top;

  logic         clk_i = 1'b0;
  logic         rst_i = 1'b1;
  logic         start_i = 1'b0;
  logic [511:0] block_i = '0;
  logic         done_o;
  logic [255:0] digest_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  sha256_block_core dut_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .start_i  (start_i),
    .block_i  (block_i),
    .done_o   (done_o),
    .digest_o (digest_o)
  );

  int unsigned kt [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  function automatic int unsigned rr(input int unsigned x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  // Behavioural reference hash of one padded block (R3, R4).
  function automatic logic [255:0] ref_digest(input logic [511:0] m);
    int unsigned w [64];
    int unsigned h [8];
    int unsigned v [8];
    int unsigned t1, t2, s0, s1;
    logic [255:0] r;
    h = '{32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
          32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
    for (int i = 0; i < 64; i++) begin
      if (i < 16) begin
        w[i] = m[511 - 32*i -: 32];
      end else begin
        s0 = rr(w[i-15], 7) ^ rr(w[i-15], 18) ^ (w[i-15] >> 3);
        s1 = rr(w[i-2], 17) ^ rr(w[i-2], 19) ^ (w[i-2] >> 10);
        w[i] = w[i-16] + s0 + w[i-7] + s1;
      end
    end
    v = h;
    for (int t = 0; t < 64; t++) begin
      t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
           + ((v[4] & v[5]) ^ (~v[4] & v[6])) + kt[t] + w[t];
      t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
           + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      for (int j = 7; j > 0; j--) v[j] = v[j-1];
      v[4] = v[4] + t1;
      v[0] = t1 + t2;
    end
    for (int j = 0; j < 8; j++) r[255 - 32*j -: 32] = v[j] + h[j];
    return r;
  endfunction

  function automatic logic [511:0] gen_block(input int unsigned seed);
    logic [511:0] b;
    int unsigned  x;
    x = seed | 1;
    for (int i = 0; i < 16; i++) begin
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      b[32*i +: 32] = x;
    end
    return b;
  endfunction

  // Cycle model: mcnt = -1 idle, 0..128 busy edges counted, 129 = done cycle.
  int           mcnt = -1;
  logic [255:0] pend_dig = '0;
  logic [255:0] held_dig = '0;

  always @(posedge clk_i) begin
    if (rst_i) begin
      mcnt     <= -1;
      held_dig <= '0;
    end else if ((mcnt == -1 || mcnt == 129) && start_i) begin
      mcnt     <= 0;
      pend_dig <= ref_digest(block_i);
    end else if (mcnt == 129) begin
      mcnt <= -1;
    end else if (mcnt >= 0) begin
      if (mcnt == 128) held_dig <= pend_dig;
      mcnt <= mcnt + 1;
    end
  end

  always @(negedge clk_i) begin
    if (!rst_i && !finished) begin
      checks++;
      if (done_o !== (mcnt == 129)) begin
        errors++;
        $display("FAIL R2 R6 done timing: actual %0b expected %0b", done_o, (mcnt == 129));
      end
      checks++;
      if (digest_o !== held_dig) begin
        errors++;
        $display("FAIL R3 R7 digest: actual %h expected %h", digest_o, held_dig);
      end
    end
  end

  task automatic chk_dig(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [511:0] b);
    @(negedge clk_i);
    start_i = 1'b1;
    block_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (done_o !== 1'b1 && n < 300) begin
      @(negedge clk_i);
      n++;
    end
    checks++;
    if (done_o !== 1'b1) begin
      errors++;
      $display("FAIL R2 no completion: actual %0b expected 1", done_o);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [511:0] abc_blk;
    logic [511:0] nul_blk;
    logic [511:0] b1;
    logic [511:0] b2;
    abc_blk = {32'h61626380, {14{32'h0}}, 32'h00000018};
    nul_blk = {32'h80000000, {15{32'h0}}};

    repeat (4) @(negedge clk_i);
    // R1: reset state, sampled while reset is held
    checks++;
    if (done_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 done after reset: actual %0b expected 0", done_o);
    end
    chk_dig("R1 digest after reset", digest_o, '0);
    rst_i = 1'b0;

    // R3 R4 R8: known result for "abc"
    send(abc_blk);
    wait_done();
    chk_dig("R3 R4 R8 abc digest", digest_o,
            256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad);

    // R3: known result for the empty message
    send(nul_blk);
    wait_done();
    chk_dig("R3 empty digest", digest_o,
            256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855);

    // R3 R4: pseudo-random blocks against the reference model
    for (int s = 1; s <= 3; s++) begin
      b1 = gen_block(32'h1234_5678 * s);
      send(b1);
      wait_done();
      chk_dig("R3 R4 random digest", digest_o, ref_digest(b1));
    end

    // R5: starts with another block during schedule and round phases are ignored
    b1 = gen_block(32'hA5A5_0001);
    b2 = gen_block(32'h5A5A_0002);
    send(b1);
    repeat (20) @(negedge clk_i);
    send(b2);
    repeat (60) @(negedge clk_i);
    send(b2);
    block_i = b2;
    wait_done();
    chk_dig("R5 busy start ignored", digest_o, ref_digest(b1));

    // R9: start in the done cycle is accepted
    b2 = gen_block(32'h0BAD_F00D);
    start_i = 1'b1;
    block_i = b2;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    checks++;
    if (done_o !== 1'b0) begin
      errors++;
      $display("FAIL R6 done after pulse: actual %0b expected 0", done_o);
    end
    wait_done();
    chk_dig("R9 back-to-back digest", digest_o, ref_digest(b2));

    // R5 R9: start held high over several jobs
    b1 = gen_block(32'hC0DE_0003);
    @(negedge clk_i);
    start_i = 1'b1;
    block_i = b1;
    repeat (300) @(negedge clk_i);
    start_i = 1'b0;
    repeat (140) @(negedge clk_i);
    chk_dig("R5 R7 held-start digest", digest_o, ref_digest(b1));

    repeat (5) @(negedge clk_i);
    summary();
  end

endmodule